// File: doc/BRIEF.md
# Calibration Pulse Sequencer

This controller issues calibration request strobes to a self-calibrating data-converter core. After power-up it waits until the supply and the references are both reported valid. The reference must become valid strictly after the supply. It then runs a startup burst: the main clock is divided by a prescaler, and every prescaler wrap produces one strobe. A gate counter counts those wraps and ends the burst on its carry-out. While the burst runs, a busy flag is raised.

Once the burst is over, the strobes come from one of two sources, chosen by a select input. The first is a slow internal periodic counter, also driven by the prescaler, which issues one strobe per carry-out. The second is the falling edge of an external calibration input, first passed through a synchronizer. Every seventh strobe after startup is also marked as the one on which a calibration really executes.

The startup sequence can be run again by pulling the restart input low and then high, or by passing through standby. All widths are parameters, so a bench can shrink the counters.

Top module: `cal_pulse_seq`

## Requirements
- R1: With restart high, standby low, supply-valid high and a qualified reference-valid high, `startup_busy_o` rises on the next clock edge.
- R2: If reference-valid is already high when supply-valid rises, with no cycle in which supply-valid is high and reference-valid is low, the block never arms and emits no strobe.
- R3: The burst keeps `startup_busy_o` high for exactly 2^(PRESC_W+GATE_W) cycles. Counting the first busy cycle as 0, it emits a strobe in every busy cycle whose index modulo 2^PRESC_W equals 2^PRESC_W-1, which is 2^GATE_W strobes in all. The defaults of 4 and 14 give 16384 strobes over 262144 clocks.
- R4: After the burst, with `int_sel_i` high, a strobe appears in run cycle k (k counted from 0 at the first non-busy cycle) exactly when k modulo 2^(PRESC_W+PERIOD_W) equals 2^(PRESC_W+PERIOD_W)-1.
- R5: After the burst, with `int_sel_i` low, the internal period produces no strobe. A high-to-low change of `ext_cal_i` applied in cycle c yields exactly one strobe, in cycle c+2.
- R6: While `startup_busy_o` is high, `ext_cal_i` and `int_sel_i` have no effect on the strobe output.
- R7: `cal_exec_o` is high together with every EXEC_DIV-th strobe (default 7) issued after the burst, counting from the end of the most recent burst. It is never high during a burst or on a burst strobe.
- R8: Restart low drops `startup_busy_o` by the next cycle and suppresses strobes at once. Returning it high with both valid flags still set re-runs a full burst.
- R9: Standby high suppresses strobes in the same cycle and drops `startup_busy_o` by the next cycle. Leaving standby re-runs a full burst.
- R10: During and right after the synchronous reset, `startup_busy_o`, `cal_pulse_o` and `cal_exec_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main clock |
| rst_n | input | 1 | Synchronous active-low reset |
| restart_i | input | 1 | High to allow startup; low clears and re-arms |
| standby_i | input | 1 | High places the block in standby |
| int_sel_i | input | 1 | High: internal periodic source; low: external input |
| ext_cal_i | input | 1 | Asynchronous external calibration request, falling edge active |
| supply_ok_i | input | 1 | Supply-valid flag |
| ref_ok_i | input | 1 | Reference-valid flag |
| cal_pulse_o | output | 1 | One-cycle calibration request strobe |
| cal_exec_o | output | 1 | Marks the strobe on which a calibration executes |
| startup_busy_o | output | 1 | High during the startup burst |

## Verification
The hardest situation to reach is the ordering rule. The reference-valid flag must already be high when the supply flag rises, with no intervening cycle that qualifies it. The bench holds the reference flag high through reset and through a later supply drop while in standby, raises the supply flag on top of it, and then watches for an arm that must not come. With shrunk counter widths, the periodic source and the seven-strobe execute marking fall within a few hundred cycles. Random external edges and random select changes during the burst then test the source switching against a bench model of the synchronizer delay.

// File: rtl/cal_seq_pkg.sv
`timescale 1ns/1ps
// Package: shared state encoding for the calibration pulse sequencer.
package cal_seq_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_BURST = 2'd1,
        ST_RUN   = 2'd2
    } seq_state_e;
endpackage

// File: rtl/cal_tick_counter.sv
`timescale 1ns/1ps
// Module: cal_tick_counter
// Wrapping binary counter with a synchronous clear. carry_o is high in the
// cycle where an increment wraps the count from all-ones back to zero.
// Assumes W >= 1. Clear has priority over increment.
module cal_tick_counter #(
    parameter int unsigned W = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic inc,
    output logic carry_o
);
    logic [W-1:0] cnt;

    // Count state: reset, clear, or step by one on inc.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (clr)
            cnt <= '0;
        else if (inc)
            cnt <= cnt + 1'b1;
    end

    assign carry_o = inc && (cnt == {W{1'b1}});
endmodule

// File: rtl/cal_order_qual.sv
`timescale 1ns/1ps
// Module: cal_order_qual
// Qualifies the reference-valid flag. It counts only once a clock edge has
// seen supply valid with reference not yet valid. The qualification is lost
// when supply drops. Assumes both flags are synchronous to clk.
module cal_order_qual (
    input  logic clk,
    input  logic rst_n,
    input  logic supply_ok_i,
    input  logic ref_ok_i,
    output logic arm_ok_o
);
    logic order_seen;

    // Remember that the reference came up after the supply.
    always_ff @(posedge clk) begin
        if (!rst_n)
            order_seen <= 1'b0;
        else if (!supply_ok_i)
            order_seen <= 1'b0;
        else if (!ref_ok_i)
            order_seen <= 1'b1;
    end

    assign arm_ok_o = order_seen && supply_ok_i && ref_ok_i;
endmodule

// File: rtl/cal_edge_sync.sv
`timescale 1ns/1ps
// Module: cal_edge_sync
// Two-flop synchronizer for an asynchronous input, followed by a history flop
// for falling-edge detection. fall_o is high for one cycle, two clock edges
// after the input falls.
module cal_edge_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic fall_o
);
    logic meta_q, sync_q, hist_q;

    // Synchronizer chain plus one stage of history.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= 1'b0;
            sync_q <= 1'b0;
            hist_q <= 1'b0;
        end else begin
            meta_q <= async_i;
            sync_q <= meta_q;
            hist_q <= sync_q;
        end
    end

    assign fall_o = hist_q && !sync_q;
endmodule

// File: rtl/cal_pulse_seq.sv
`timescale 1ns/1ps
// Module: cal_pulse_seq (top)
// Sequences calibration strobes: an ordered arm of the supply and reference
// flags, a startup burst ended by a gate counter, then either an internal
// periodic source or a synchronized external falling edge. Every EXEC_DIV-th
// post-startup strobe is marked as executing. Restart low or standby high
// clears everything and re-arms. Assumes EXEC_DIV >= 2.
module cal_pulse_seq #(
    parameter int unsigned PRESC_W  = 4,
    parameter int unsigned GATE_W   = 14,
    parameter int unsigned PERIOD_W = 24,
    parameter int unsigned EXEC_DIV = 7
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart_i,
    input  logic standby_i,
    input  logic int_sel_i,
    input  logic ext_cal_i,
    input  logic supply_ok_i,
    input  logic ref_ok_i,
    output logic cal_pulse_o,
    output logic cal_exec_o,
    output logic startup_busy_o
);
    import cal_seq_pkg::*;

    localparam int unsigned EXEC_W = $clog2(EXEC_DIV);
    localparam logic [EXEC_W-1:0] EXEC_LAST = EXEC_W'(EXEC_DIV - 1);

    seq_state_e state_q;
    logic hold, run_en, arm_ok, ext_fall;
    logic tick, gate_carry, period_carry;
    logic burst_pulse, post_pulse;
    logic [EXEC_W-1:0] exec_cnt;

    assign hold   = !restart_i || standby_i;
    assign run_en = (state_q != ST_IDLE) && !hold;

    cal_order_qual u_qual (
        .clk         (clk),
        .rst_n       (rst_n),
        .supply_ok_i (supply_ok_i),
        .ref_ok_i    (ref_ok_i),
        .arm_ok_o    (arm_ok)
    );

    cal_edge_sync u_ext (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (ext_cal_i),
        .fall_o  (ext_fall)
    );

    cal_tick_counter #(.W(PRESC_W)) u_presc (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (state_q == ST_IDLE),
        .inc     (run_en),
        .carry_o (tick)
    );

    cal_tick_counter #(.W(GATE_W)) u_gate (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (state_q != ST_BURST),
        .inc     (tick && (state_q == ST_BURST)),
        .carry_o (gate_carry)
    );

    cal_tick_counter #(.W(PERIOD_W)) u_period (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (state_q != ST_RUN),
        .inc     (tick && (state_q == ST_RUN)),
        .carry_o (period_carry)
    );

    // Sequence state: idle until armed, burst until gate carry, then run.
    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else if (hold)
            state_q <= ST_IDLE;
        else begin
            case (state_q)
                ST_IDLE:  if (arm_ok) state_q <= ST_BURST;
                ST_BURST: if (gate_carry) state_q <= ST_RUN;
                ST_RUN:   state_q <= ST_RUN;
                default:  state_q <= ST_IDLE;
            endcase
        end
    end

    assign burst_pulse = tick && (state_q == ST_BURST);
    assign post_pulse  = (state_q == ST_RUN) && !hold &&
                         (int_sel_i ? period_carry : ext_fall);

    // Count post-startup strobes modulo EXEC_DIV.
    always_ff @(posedge clk) begin
        if (!rst_n)
            exec_cnt <= '0;
        else if (state_q != ST_RUN)
            exec_cnt <= '0;
        else if (post_pulse)
            exec_cnt <= (exec_cnt == EXEC_LAST) ? '0 : exec_cnt + 1'b1;
    end

    assign cal_pulse_o    = burst_pulse || post_pulse;
    assign cal_exec_o     = post_pulse && (exec_cnt == EXEC_LAST);
    assign startup_busy_o = (state_q == ST_BURST);
endmodule

// File: rtl/cal_pulse_seq_chk.sv
`timescale 1ns/1ps
// Module: cal_pulse_seq_chk
// Port-level properties of the calibration pulse sequencer, bound to the top.
module cal_pulse_seq_chk (
    input logic clk,
    input logic rst_n,
    input logic restart_i,
    input logic standby_i,
    input logic supply_ok_i,
    input logic ref_ok_i,
    input logic cal_pulse_o,
    input logic cal_exec_o,
    input logic startup_busy_o
);
    // R7
    exec_needs_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cal_exec_o |-> cal_pulse_o);

    // R7
    exec_outside_burst_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cal_exec_o |-> !startup_busy_o);

    // R8
    restart_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !restart_i |=> !startup_busy_o);

    // R9
    standby_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        standby_i |-> !cal_pulse_o);

    // R9
    standby_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        standby_i |=> !startup_busy_o);

    // R1
    arm_inputs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(startup_busy_o) |->
            $past(supply_ok_i && ref_ok_i && restart_i && !standby_i));
endmodule

bind cal_pulse_seq cal_pulse_seq_chk u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .restart_i      (restart_i),
    .standby_i      (standby_i),
    .supply_ok_i    (supply_ok_i),
    .ref_ok_i       (ref_ok_i),
    .cal_pulse_o    (cal_pulse_o),
    .cal_exec_o     (cal_exec_o),
    .startup_busy_o (startup_busy_o)
);

// File: tb/cal_pulse_seq_tb.sv
`timescale 1ns/1ps
module cal_pulse_seq_tb;
    localparam int P  = 2;
    localparam int S  = 3;
    localparam int W  = 4;
    localparam int ED = 7;

    logic clk = 1'b0;
    logic rst_n, restart, standby, sel, cal, supply, refok;
    logic pulse, exec_o, busy;
    int total = 0;
    int bad = 0;
    int npost = 0;
    int seed_init;

    always #10 clk = ~clk;

    cal_pulse_seq #(.PRESC_W(P), .GATE_W(S), .PERIOD_W(W), .EXEC_DIV(ED)) u_dut (
        .clk(clk), .rst_n(rst_n), .restart_i(restart), .standby_i(standby),
        .int_sel_i(sel), .ext_cal_i(cal), .supply_ok_i(supply), .ref_ok_i(refok),
        .cal_pulse_o(pulse), .cal_exec_o(exec_o), .startup_busy_o(busy)
    );

    function automatic int burst_len();    return 1 << (P + S); endfunction
    function automatic int burst_pulses(); return 1 << S;       endfunction
    function automatic int prescale();     return 1 << P;       endfunction
    function automatic int period();       return 1 << (P + W); endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%0d exp=%0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #5;
    endtask

    // Walk a burst from its first busy cycle; check spacing, length, count (R3, R6, R7).
    task automatic run_burst();
        int i = 0;
        int np = 0;
        while (busy && i < burst_len() + 5) begin
            chk(pulse == ((i % prescale()) == prescale() - 1), "R3 burst strobe", pulse, ((i % prescale()) == prescale() - 1));
            chk(exec_o == 1'b0, "R7 no exec in burst", exec_o, 0);
            if (pulse) np++;
            if (i < burst_len() - 4) begin
                sel = 1'($urandom % 2);   // R6: source inputs toggled during burst
                cal = 1'($urandom % 2);
            end else begin
                sel = 1'b1;
                cal = 1'b1;
            end
            step();
            i++;
        end
        chk(i == burst_len(), "R3 burst length", i, burst_len());
        chk(np == burst_pulses(), "R6 burst strobe count", np, burst_pulses());
        npost = 0;
    endtask

    initial begin
        #4_000_000;
        total++;
        bad++;
        $display("FAIL watchdog act=0 exp=1");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        bit saw_bad;
        seed_init = $urandom(32'd20240611);
        rst_n = 0; restart = 1; standby = 0; sel = 1; cal = 1; supply = 0; refok = 1;
        repeat (4) step();
        chk(!busy && !pulse && !exec_o, "R10 reset outputs", {busy, pulse, exec_o}, 0);
        rst_n = 1;
        step();
        chk(!busy && !pulse && !exec_o, "R10 after reset", {busy, pulse, exec_o}, 0);

        // R2: reference already valid when supply rises
        supply = 1;
        saw_bad = 0;
        repeat (40) begin step(); if (busy || pulse) saw_bad = 1; end
        chk(!saw_bad, "R2 no arm when ref first", saw_bad, 0);

        // R1: proper order arms on the next edge
        refok = 0;
        repeat (3) step();
        chk(!busy, "R1 not armed while ref low", busy, 0);
        refok = 1;
        step();
        chk(busy, "R1 armed next edge", busy, 1);
        run_burst();

        // R4 and R7: periodic source
        for (int j = 0; j < 8 * period(); j++) begin
            bit expp;
            bit expe;
            expp = ((j % period()) == period() - 1);
            expe = 0;
            if (expp) begin npost++; expe = (npost % ED) == 0; end
            if (pulse !== expp) chk(0, "R4 periodic strobe", pulse, expp);
            if (exec_o !== expe) chk(0, "R7 exec periodic", exec_o, expe);
            step();
        end
        chk(npost == 8, "R4 periodic count", npost, 8);

        // R5: external source with random edges
        begin
            bit d1 = 1, d2 = 1, d3 = 1;
            int nfall = 0;
            sel = 0;
            for (int c = 0; c < 300; c++) begin
                bit expp;
                bit expe;
                bit v;
                expp = d3 && !d2;
                expe = 0;
                if (expp) begin npost++; nfall++; expe = (npost % ED) == 0; end
                if (pulse !== expp) chk(0, "R5 external strobe", pulse, expp);
                if (exec_o !== expe) chk(0, "R7 exec external", exec_o, expe);
                v = ($urandom % 3) != 0;
                cal = v;
                d3 = d2; d2 = d1; d1 = v;
                step();
            end
            chk(nfall > 10, "R5 external edges seen", nfall, 11);
        end
        cal = 1; sel = 1;
        repeat (4) step();

        // R8: restart low then high
        restart = 0;
        #1;
        chk(!pulse, "R8 strobe suppressed", pulse, 0);
        saw_bad = 0;
        repeat (5) begin step(); if (busy || pulse) saw_bad = 1; end
        chk(!saw_bad, "R8 held idle", saw_bad, 0);
        restart = 1;
        step();
        chk(busy, "R8 re-armed", busy, 1);
        run_burst();

        // R9: standby mid-burst
        restart = 0; step(); restart = 1; step();
        chk(busy, "R9 armed before standby", busy, 1);
        repeat (5) step();
        standby = 1;
        #1;
        chk(!pulse, "R9 strobe gated", pulse, 0);
        saw_bad = 0;
        repeat (6) begin step(); if (busy || pulse) saw_bad = 1; end
        chk(!saw_bad, "R9 standby quiet", saw_bad, 0);
        standby = 0;
        step();
        chk(busy, "R9 rerun after standby", busy, 1);
        run_burst();

        // R2 again: supply drops and returns over an already-valid reference
        standby = 1; step();
        supply = 0; step();
        supply = 1; step();
        standby = 0;
        saw_bad = 0;
        repeat (40) begin step(); if (busy || pulse) saw_bad = 1; end
        chk(!saw_bad, "R2 no arm after supply bounce", saw_bad, 0);
        refok = 0; step(); refok = 1; step();
        chk(busy, "R1 arm after reordering", busy, 1);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule